// File: doc/BRIEF.md
# BCD calendar clock core

This core keeps wall-clock time from seconds up to years as packed BCD bytes. A 32.768 kHz tick enable, sampled in the core's single clock domain, drives a sub-second prescaler. Whenever the prescaler completes a second, the time fields advance with full calendar roll-over. Month lengths and leap years are handled for the span 2000 to 2099. A weekday counter advances alongside the day.

Software reaches the core through a flat byte register port. It has one write channel (enable, address, data) and a combinational read channel (address in, data out). A busy indication rises a few ticks before every update. Once busy has fallen, software can read or rewrite the time without tearing. Four sticky event flags record second, minute, hour and day roll-overs, and the second flag can be routed to an interrupt output.

The register map uses word indices. Index 0 holds seconds, 1 minutes, 2 hours, 3 day of month, 4 month and 5 year. Index 6 holds the weekday, 8 the control byte, 9 the status byte and 10 the interrupt enable. Every other index reads zero.

Top module: `bcd_calendar_core`

## Requirements
- R1: Control (index 8) bit 0 is the run bit. While it is 1 the prescaler counts tick enables. While it is 0, all time fields and the prescaler hold their values. Control reads back only bit 0, and bits 7..1 always read zero.
- R2: Seconds (index 0) and minutes (index 1) go from 0x59 to 0x00 and carry into the next field. Hours (index 2) go from 0x23 to 0x00 and carry into the day.
- R3: The day of month (index 3) wraps to 0x01 after its last day: 0x31, 0x30 for months 0x04/0x06/0x09/0x11, and 0x28 for February (0x29 when the binary year is divisible by 4). The wrap carries into the month (index 4, 0x01..0x12), which wraps from 0x12 to 0x01 and carries into the year (index 5, 0x00..0x99, wrapping from 0x99 to 0x00).
- R4: The weekday (index 6, 0x00..0x06) advances on each day roll-over and wraps from 0x06 to 0x00.
- R5: While running, one second lasts TICKS_PER_SEC tick enables. The busy flag (status bit 0 and the `busy` port) is high during the last BUSY_TICKS prescaler counts of each second. Fields change only at the tick that ends that window.
- R6: Status (index 9) reads {2'b00, day flag, hour flag, minute flag, second flag, run, busy}, from bit 7 down to bit 0. Each event flag is set by its roll-over and stays set until it is cleared.
- R7: Writing status clears every flag whose bit among 5..2 is 1 and leaves the others. Bits 1..0 ignore writes. When a roll-over and a clear hit the same flag in the same cycle, the flag ends up set.
- R8: The `irq` output equals interrupt-enable (index 10) bit 0 AND the second flag. The enable register reads back as {7'b0, enable}.
- R9: A write to any time field (indices 0..6) is visible from the next cycle. It restarts the prescaler at zero, suppresses any update due in that cycle, and so the next second completes a full TICKS_PER_SEC ticks later.
- R10: After reset, the time reads 00:00:00, day 0x01, month 0x01, year 0x00, weekday 0x00. The core is stopped, with all flags and the enable at zero.
- R11: Reads of indices 7 and 11..15 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle 32.768 kHz tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write index |
| wr_data | input | 8 | Register write data |
| rd_addr | input | ADDR_W | Register read index |
| rd_data | output | 8 | Read data, combinational on rd_addr |
| busy | output | 1 | Update imminent |
| irq | output | 1 | Periodic second interrupt |

## Verification
Every register result is due one clock after the edge that sees the write or the last tick of a second. Because `rd_data` follows `rd_addr` combinationally, a changed field is readable in that same following cycle, and `busy` and `irq` also change one edge after their cause. The bench's behavioural model steps at the same rising edge from the same inputs. It is compared with the outputs at the next falling edge, so a result that comes one cycle early or late is caught. The directed peeks count falling edges from the write that restarted the prescaler, and so land on the exact cycle before and after an update.

// File: rtl/cal_pkg.sv
package cal_pkg;

  // Field order places seconds in the least significant byte
  typedef struct packed {
    logic [7:0] wday;
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] day;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_time_t;

  localparam int unsigned FIELDS = 7;

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] year);
    logic [6:0] y;
    y = bcd_bin(year);
    case (mon)
      8'h02: return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned BUSY_TICKS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick_en,
  input  logic restart,
  output logic sec_strobe,
  output logic busy
);
  localparam int unsigned CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST      = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] BUSY_FROM = CW'(TICKS_PER_SEC - BUSY_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (restart)        cnt <= '0;
    else if (run && tick_en) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end

  assign sec_strobe = run & tick_en & ~restart & (cnt == LAST);
  assign busy       = run & (cnt >= BUSY_FROM);
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_strobe,
  input  logic [FIELDS-1:0] load,
  input  logic [7:0]        load_data,
  output cal_time_t         now,
  output logic [3:0]        roll
);
  localparam cal_time_t RESET_TIME = '{wday: 8'h00, year: 8'h00, mon: 8'h01,
                                       day: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  logic [FIELDS-1:0][7:0] regs;
  logic [FIELDS-1:0][7:0] nxt_arr;
  logic [FIELDS-1:0][7:0] rst_arr;
  cal_time_t nxt;
  logic wrap_sec, wrap_min, wrap_hour, wrap_day, wrap_mon;

  assign now     = cal_time_t'(regs);
  assign rst_arr = RESET_TIME;

  assign wrap_sec  = (now.sec == 8'h59);
  assign wrap_min  = wrap_sec & (now.min == 8'h59);
  assign wrap_hour = wrap_min & (now.hour == 8'h23);
  assign wrap_day  = wrap_hour & (now.day == month_end(now.mon, now.year));
  assign wrap_mon  = wrap_day & (now.mon == 8'h12);

  // roll[0] second, [1] minute, [2] hour, [3] day
  assign roll = sec_strobe ? {wrap_hour, wrap_min, wrap_sec, 1'b1} : 4'b0000;

  always_comb begin
    nxt = now;
    if (sec_strobe) begin
      nxt.sec = wrap_sec ? 8'h00 : bcd_next(now.sec);
      if (wrap_sec)  nxt.min  = wrap_min ? 8'h00 : bcd_next(now.min);
      if (wrap_min)  nxt.hour = wrap_hour ? 8'h00 : bcd_next(now.hour);
      if (wrap_hour) begin
        nxt.day  = wrap_day ? 8'h01 : bcd_next(now.day);
        nxt.wday = (now.wday == 8'h06) ? 8'h00 : bcd_next(now.wday);
      end
      if (wrap_day)  nxt.mon  = wrap_mon ? 8'h01 : bcd_next(now.mon);
      if (wrap_mon)  nxt.year = (now.year == 8'h99) ? 8'h00 : bcd_next(now.year);
    end
  end

  assign nxt_arr = nxt;

  for (genvar i = 0; i < FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)       regs[i] <= rst_arr[i];
      else if (load[i]) regs[i] <= load_data;
      else              regs[i] <= nxt_arr[i];
    end
  end
endmodule

// File: rtl/cal_events.sv
module cal_events #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= set[i] | (flags[i] & ~clr[i]);
    end
  end
endmodule

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core
  import cal_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned BUSY_TICKS    = 4,
  parameter int unsigned ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] IDX_SEC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IDX_MIN  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IDX_HOUR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IDX_DAY  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IDX_MON  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] IDX_YEAR = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] IDX_WDAY = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] IDX_CTRL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] IDX_STAT = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] IDX_IEN  = ADDR_W'(10);

  logic [FIELDS-1:0] load;
  logic              field_wr;
  logic              sec_strobe;
  logic              run_q, ien_q;
  logic [3:0]        roll, flags, ev_clr;
  cal_time_t         now;

  for (genvar i = 0; i < FIELDS; i++) begin : g_load
    assign load[i] = wr_en & (wr_addr == ADDR_W'(i));
  end
  assign field_wr = |load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == IDX_CTRL) run_q <= wr_data[0];
      if (wr_addr == IDX_IEN)  ien_q <= wr_data[0];
    end
  end

  assign ev_clr = (wr_en && wr_addr == IDX_STAT) ? wr_data[5:2] : 4'b0000;

  cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .BUSY_TICKS(BUSY_TICKS)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .tick_en(tick_en),
    .restart(field_wr), .sec_strobe(sec_strobe), .busy(busy)
  );

  cal_counter u_count (
    .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe), .load(load),
    .load_data(wr_data), .now(now), .roll(roll)
  );

  cal_events #(.N(4)) u_events (
    .clk(clk), .rst_n(rst_n), .set(roll), .clr(ev_clr), .flags(flags)
  );

  assign irq = ien_q & flags[0];

  always_comb begin
    case (rd_addr)
      IDX_SEC:  rd_data = now.sec;
      IDX_MIN:  rd_data = now.min;
      IDX_HOUR: rd_data = now.hour;
      IDX_DAY:  rd_data = now.day;
      IDX_MON:  rd_data = now.mon;
      IDX_YEAR: rd_data = now.year;
      IDX_WDAY: rd_data = now.wday;
      IDX_CTRL: rd_data = {7'b0, run_q};
      IDX_STAT: rd_data = {2'b00, flags, run_q, busy};
      IDX_IEN:  rd_data = {7'b0, ien_q};
      default:  rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sec_strobe,
  input logic       busy,
  input logic       run_q,
  input logic       field_wr,
  input logic       ien_q,
  input logic       irq,
  input cal_time_t  now,
  input logic [3:0] flags,
  input logic [3:0] ev_clr
);
  // R5: an update only happens inside the busy window
  p_busy_leads_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_strobe |-> busy);

  // R1: a stopped core with no field write holds its time
  p_frozen_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !field_wr) |=> $stable(now));

  // R2: seconds wrap to zero
  p_second_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && now.sec == 8'h59) |=> (now.sec == 8'h00));

  // R6: flags stay set unless cleared
  p_sec_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !ev_clr[0]) |=> flags[0]);
  p_day_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[3] && !ev_clr[3]) |=> flags[3]);

  // R8: an enabled second update raises the interrupt
  p_irq_follows_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_strobe && ien_q) |=> irq);

  // R9: a field write restarts the prescaler, leaving the busy window
  p_write_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    field_wr |=> !busy);
endmodule

bind bcd_calendar_core cal_checker u_cal_checker (
  .clk(clk), .rst_n(rst_n), .sec_strobe(sec_strobe), .busy(busy),
  .run_q(run_q), .field_wr(field_wr), .ien_q(ien_q), .irq(irq),
  .now(now), .flags(flags), .ev_clr(ev_clr)
);

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;
  localparam int TPS  = 8;
  localparam int BUSY = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int tick_gap = 1;
  int tcnt = 0;

  // reference model state (binary)
  int m_sec, m_min, m_hr, m_day, m_mon, m_yr, m_wd, m_presc;
  bit m_run, m_ien;
  bit [3:0] m_flags;

  bcd_calendar_core #(.TICKS_PER_SEC(TPS), .BUSY_TICKS(BUSY), .ADDR_W(4)) i_bcd_calendar_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic int days_of(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return to_bcd(m_sec);
      4'd1: return to_bcd(m_min);
      4'd2: return to_bcd(m_hr);
      4'd3: return to_bcd(m_day);
      4'd4: return to_bcd(m_mon);
      4'd5: return to_bcd(m_yr);
      4'd6: return to_bcd(m_wd);
      4'd8: return {7'b0, m_run};
      4'd9: return {2'b00, m_flags, m_run, model_busy()};
      4'd10: return {7'b0, m_ien};
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit model_busy();
    return m_run && (m_presc >= TPS - BUSY);
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2: return "R2";
      4'd3, 4'd4, 4'd5: return "R3";
      4'd6: return "R4";
      4'd8: return "R1";
      4'd9: return "R6";
      4'd10: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, stepped at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_mon = 1; m_yr = 0; m_wd = 0;
      m_presc = 0; m_run = 0; m_ien = 0; m_flags = '0;
    end else begin
      bit fw;
      bit [3:0] ev;
      bit [3:0] clr;
      fw = wr_en && (wr_addr <= 4'd6);
      ev = '0;
      if (fw) begin
        case (wr_addr)
          4'd0: m_sec = from_bcd(wr_data);
          4'd1: m_min = from_bcd(wr_data);
          4'd2: m_hr  = from_bcd(wr_data);
          4'd3: m_day = from_bcd(wr_data);
          4'd4: m_mon = from_bcd(wr_data);
          4'd5: m_yr  = from_bcd(wr_data);
          default: m_wd = from_bcd(wr_data);
        endcase
        m_presc = 0;
      end else if (m_run && tick_en) begin
        if (m_presc == TPS - 1) begin
          m_presc = 0;
          ev[0] = 1;
          m_sec++;
          if (m_sec == 60) begin
            m_sec = 0; ev[1] = 1; m_min++;
            if (m_min == 60) begin
              m_min = 0; ev[2] = 1; m_hr++;
              if (m_hr == 24) begin
                m_hr = 0; ev[3] = 1; m_wd = (m_wd + 1) % 7;
                if (m_day == days_of(m_mon, m_yr)) begin
                  m_day = 1; m_mon++;
                  if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
                end else m_day++;
              end
            end
          end
        end else m_presc++;
      end
      if (wr_en && wr_addr == 4'd8)  m_run = wr_data[0];
      if (wr_en && wr_addr == 4'd10) m_ien = wr_data[0];
      clr = (wr_en && wr_addr == 4'd9) ? wr_data[5:2] : 4'b0;
      m_flags = (m_flags & ~clr) | ev;
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag_of(rd_addr), int'(rd_data), int'(model_read(rd_addr)));
      chk("R5 busy", int'(busy), int'(model_busy()));
      chk("R8 irq", int'(irq), int'(m_ien && m_flags[0]));
    end
    tcnt++;
    tick_en = (tcnt % tick_gap) == 0;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_addr = 4'(i % 16);
    end
  endtask

  task automatic peek(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    chk(tag, int'(rd_data), int'(exp));
  endtask

  task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dy,
                          input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                          input logic [7:0] wd);
    wr(4'd5, yr); wr(4'd4, mo); wr(4'd3, dy); wr(4'd2, hr);
    wr(4'd1, mi); wr(4'd0, se); wr(4'd6, wd);
  endtask

  // run for one second from :59 and stop before the next update
  task automatic one_second();
    wr(4'd8, 8'h01);
    idle(TPS + 1);
    wr(4'd8, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state
    peek(4'd0, 8'h00, "R10 sec");
    peek(4'd3, 8'h01, "R10 day");
    peek(4'd4, 8'h01, "R10 month");
    peek(4'd8, 8'h00, "R10 ctrl");
    peek(4'd9, 8'h00, "R10 status");
    peek(4'd11, 8'h00, "R11 unused index");

    // R3 R4 R2: century roll-over from 2099-12-31 23:59:57, weekday 6
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h57, 8'h06);
    wr(4'd8, 8'h01);
    idle(3 * TPS + 1);
    wr(4'd8, 8'h00);
    peek(4'd5, 8'h00, "R3 year wraps");
    peek(4'd4, 8'h01, "R3 month wraps");
    peek(4'd3, 8'h01, "R3 day wraps");
    peek(4'd2, 8'h00, "R2 hour wraps");
    peek(4'd0, 8'h00, "R2 second wraps");
    peek(4'd6, 8'h00, "R4 weekday wraps");
    peek(4'd9, 8'h3C, "R6 all flags set");

    // R7: write-one-to-clear, read-only low bits
    wr(4'd9, 8'h0C);
    peek(4'd9, 8'h30, "R7 partial clear");
    wr(4'd9, 8'h03);
    peek(4'd9, 8'h30, "R7 low bits ignored");
    wr(4'd9, 8'h3C);

    // R3: leap and non-leap February, 30-day month
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h02);
    one_second();
    peek(4'd3, 8'h29, "R3 leap Feb 29");
    set_time(8'h24, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59, 8'h03);
    one_second();
    peek(4'd4, 8'h03, "R3 leap Feb end month");
    peek(4'd3, 8'h01, "R3 leap Feb end day");
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h01);
    one_second();
    peek(4'd4, 8'h03, "R3 common Feb end");
    set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, 8'h01);
    one_second();
    peek(4'd3, 8'h29, "R3 year 00 is leap");
    set_time(8'h31, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59, 8'h04);
    one_second();
    peek(4'd4, 8'h05, "R3 30-day month");
    peek(4'd6, 8'h05, "R4 weekday step");

    // R1: frozen while stopped, control readback masks upper bits
    set_time(8'h10, 8'h06, 8'h15, 8'h12, 8'h30, 8'h20, 8'h02);
    idle(5 * TPS);
    peek(4'd0, 8'h20, "R1 frozen when stopped");
    wr(4'd8, 8'hFF);
    peek(4'd8, 8'h01, "R1 ctrl readback");

    // R8: interrupt on second flag
    wr(4'd9, 8'h3C);
    wr(4'd10, 8'h01);
    peek(4'd10, 8'h01, "R8 enable readback");
    idle(TPS + 1);
    chk("R8 irq raised", int'(irq), 1);
    wr(4'd9, 8'h04);
    chk("R8 irq cleared", int'(irq), 0);

    // R9 R5: field write restarts the prescaler mid-second
    idle(3);
    wr(4'd0, 8'h10);
    idle(6);
    peek(4'd0, 8'h10, "R9 no early update");
    chk("R5 busy before update", int'(busy), 1);
    peek(4'd0, 8'h11, "R9 update after full second");
    chk("R5 busy drops after update", int'(busy), 0);

    // R5: slower tick rate, model keeps comparing every cycle
    tick_gap = 3;
    idle(3 * TPS * 3 + 5);
    tick_gap = 1;
    wr(4'd8, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule